// File: doc/BRIEF.md
# Load/Store Lane Alignment and Extension Unit

This unit sits between the pipeline's memory stage, a 64-bit data memory port and the register write-back path. Each request carries a byte address, an access size, a signed/unsigned flag for loads, a load/store flag and, for stores, the value to write. The unit first checks the access for natural alignment.

A naturally aligned access goes to memory in the same cycle it is presented, so it costs no extra cycle. The unit sends the memory a doubleword address and, for stores, per-byte enables and write data moved into the right byte lanes. The synchronous memory returns the 64-bit read word one cycle later. The unit then picks the addressed lane in little-endian order and extends it to a full 64-bit register value.

A misaligned access never reaches memory and never writes a register. Instead, one cycle after the request the unit raises a trap and holds the faulting address so the exception logic can capture it. Splitting a misaligned access into two memory cycles is deliberately not done.

Top module: `mem_lane_align`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wb_valid` and `trap` are low.
- R2: Size encoding is 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. An access is misaligned when a halfword has address bit 0 set, a word has either of address bits 1:0 set, or a doubleword has any of address bits 2:0 set. A byte is never misaligned. A misaligned request never asserts `mem_req`.
- R3: A valid aligned request asserts `mem_req` in the same cycle. `mem_we` equals the store flag, and `mem_addr` is the request address with bits 2:0 cleared.
- R4: The cycle after a misaligned request, `trap` is high for one cycle and `wb_valid` stays low. `trap_addr` holds the full faulting address, and `trap_is_store` holds the request's store flag.
- R5: The cycle after an aligned load request, `wb_valid` is high for one cycle and `trap` is low. `wb_data` is formed from `mem_rdata` as presented in that cycle.
- R6: Lanes are little-endian. Address bits 2:0 give the byte offset k, and the loaded value starts at `mem_rdata[8k+7:8k]`, with higher-numbered bytes holding more significant bits.
- R7: An unsigned byte, halfword or word load fills every bit of `wb_data` above the loaded width with zero.
- R8: A signed byte, halfword or word load fills every bit of `wb_data` above the loaded width with the loaded value's top bit. A doubleword load returns `mem_rdata` unchanged, whatever the signed flag.
- R9: For an aligned store of 2^size bytes at offset k, `mem_be` bit i (one bit per byte lane, bit i for `mem_wdata[8i+7:8i]`) is set exactly for k <= i < k + 2^size.
- R10: For an aligned store, `mem_wdata` equals `req_wdata` shifted left by 8k bits, with the vacated low lanes zero.
- R11: A store request, or a cycle with `req_valid` low, is followed by a cycle with `wb_valid` low. A cycle with `req_valid` low asserts neither `mem_req` nor, on the next cycle, `trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_signed | input | 1 | Load extension: 1 sign, 0 zero |
| req_addr | input | ADDR_W | Byte effective address |
| req_wdata | input | DATA_W | Store value, right-justified |
| mem_req | output | 1 | Memory access issued this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Doubleword-aligned memory address |
| mem_be | output | DATA_W/8 | Store byte-lane enables |
| mem_wdata | output | DATA_W | Lane-shifted store data |
| mem_rdata | input | DATA_W | Read word, valid the cycle after a load request |
| wb_valid | output | 1 | Load result ready for write-back |
| wb_data | output | DATA_W | Extended load result |
| trap | output | 1 | Misalignment trap |
| trap_is_store | output | 1 | Trapped access was a store |
| trap_addr | output | ADDR_W | Faulting address |

## Verification
Every cycle, the assertions check four properties:
- a misaligned request never reaches memory, and the enable count matches the access size;
- each accepted request is answered in exactly the next cycle by either a load result or a trap, never both, and a store produces no result;
- the trap address equals the faulting request address;
- a doubleword result passes the memory word through untouched.

Only the bench's sweep can show that the right byte lane is selected at each of the eight offsets, that sign and zero fill produce the exact upper bits, and that store data lands in the right lanes. The sweep covers every size, offset, sign mode and direction, using read words whose byte top bits are either all set or all clear.

// File: rtl/mla_pkg.sv
package mla_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   // Low-address bits that must be zero for a natural alignment of this size
   function automatic logic [2:0] align_mask(input logic [1:0] sz);
      logic [2:0] m;
      case (sz)
         2'd0:    m = 3'b000;
         2'd1:    m = 3'b001;
         2'd2:    m = 3'b011;
         default: m = 3'b111;
      endcase
      return m;
   endfunction

   // Number of bytes touched, as a 4-bit count
   function automatic logic [3:0] size_bytes(input logic [1:0] sz);
      return 4'd1 << sz;
   endfunction

endpackage

// File: rtl/mla_align_check.sv
module mla_align_check
   import mla_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_size,
   input  logic [2:0] addr_lo,
   output logic       misaligned
);

   logic [2:0] mask;

   always_comb begin
      mask       = align_mask(req_size);
      misaligned = |(addr_lo & mask);
   end

   // A byte access can never be misaligned (R2)
   p_byte_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd0) |-> !misaligned);

   // Any doubleword access with nonzero offset is misaligned (R2)
   p_dword_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd3 && addr_lo != 3'd0) |-> misaligned);

endmodule

// File: rtl/mla_store_lane.sv
module mla_store_lane
   import mla_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [1:0]        size,
   input  logic [OFF_W-1:0]  offset,
   input  logic [DATA_W-1:0] wdata_in,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] wdata_out
);

   logic [OFF_W:0] first_lane;
   logic [OFF_W:0] end_lane;

   always_comb begin
      first_lane = {1'b0, offset};
      end_lane   = first_lane + (OFF_W+1)'(size_bytes(size));
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [OFF_W:0] IDX = (OFF_W+1)'(i);
      always_comb begin
         be[i] = active && (IDX >= first_lane) && (IDX < end_lane);
      end
   end

   always_comb begin
      wdata_out = wdata_in << {offset, 3'b000};
   end

   // Byte enable count equals access width whenever active (R9)
   p_be_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> ($countones(be) == int'(size_bytes(size))));

   // Lowest enabled lane is the offset (R9)
   p_be_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> be[offset]);

endmodule

// File: rtl/mla_load_extract.sv
module mla_load_extract
   import mla_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES),
   localparam int NSIZE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [1:0]        size,
   input  logic              is_signed,
   input  logic [OFF_W-1:0]  offset,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] result
);

   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] ext_v [NSIZE];

   always_comb begin
      shifted = rdata >> {offset, 3'b000};
   end

   for (genvar s = 0; s < NSIZE; s++) begin : g_size
      localparam int W = 8 << s;
      if (W >= DATA_W) begin : g_full
         always_comb ext_v[s] = shifted;
      end else begin : g_narrow
         logic [W-1:0] slice;
         logic         fill;
         always_comb begin
            slice    = shifted[W-1:0];
            fill     = is_signed & slice[W-1];
            ext_v[s] = {{(DATA_W-W){fill}}, slice};
         end
      end
   end

   always_comb begin
      result = ext_v[size];
   end

   // Doubleword result is the memory word untouched (R8)
   p_dword_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && size == 2'd3) |-> (result == rdata));

   // Unsigned byte result has zero upper bits (R7)
   p_ubyte_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && size == 2'd0 && !is_signed) |-> (result[DATA_W-1:8] == '0));

endmodule

// File: rtl/mem_lane_align.sv
module mem_lane_align
   import mla_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_is_store,
   input  logic [1:0]            req_size,
   input  logic                  req_signed,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W/8-1:0]   mem_be,
   output logic [DATA_W-1:0]     mem_wdata,
   input  logic [DATA_W-1:0]     mem_rdata,
   output logic                  wb_valid,
   output logic [DATA_W-1:0]     wb_data,
   output logic                  trap,
   output logic                  trap_is_store,
   output logic [ADDR_W-1:0]     trap_addr
);

   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);

   if (DATA_W != 64) begin : g_bad_data_w
      $error("mem_lane_align: DATA_W must be 64 to hold a doubleword");
   end
   if (ADDR_W < OFF_W + 1) begin : g_bad_addr_w
      $error("mem_lane_align: ADDR_W too narrow for lane offset");
   end

   logic             misaligned;
   logic             issue;
   logic             store_go;
   logic [OFF_W-1:0] offset;

   logic             load_q;
   logic [1:0]       size_q;
   logic             signed_q;
   logic [OFF_W-1:0] off_q;
   logic             trap_q;
   logic             trap_st_q;
   logic [ADDR_W-1:0] trap_addr_q;

   always_comb begin
      offset = req_addr[OFF_W-1:0];
   end

   mla_align_check u_align (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_size   (req_size),
      .addr_lo    (req_addr[2:0]),
      .misaligned (misaligned)
   );

   always_comb begin
      issue    = req_valid && !misaligned;
      store_go = issue && req_is_store;
      mem_req  = issue;
      mem_we   = store_go;
      mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   end

   mla_store_lane #(.DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (store_go),
      .size      (req_size),
      .offset    (offset),
      .wdata_in  (req_wdata),
      .be        (mem_be),
      .wdata_out (mem_wdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_q      <= 1'b0;
         trap_q      <= 1'b0;
         trap_st_q   <= 1'b0;
         trap_addr_q <= '0;
         size_q      <= 2'd0;
         signed_q    <= 1'b0;
         off_q       <= '0;
      end else begin
         load_q <= issue && !req_is_store;
         trap_q <= req_valid && misaligned;
         if (req_valid && misaligned) begin
            trap_st_q   <= req_is_store;
            trap_addr_q <= req_addr;
         end
         if (issue && !req_is_store) begin
            size_q   <= req_size;
            signed_q <= req_signed;
            off_q    <= offset;
         end
      end
   end

   mla_load_extract #(.DATA_W(DATA_W)) u_load (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (load_q),
      .size      (size_q),
      .is_signed (signed_q),
      .offset    (off_q),
      .rdata     (mem_rdata),
      .result    (wb_data)
   );

   always_comb begin
      wb_valid      = load_q;
      trap          = trap_q;
      trap_is_store = trap_st_q;
      trap_addr     = trap_addr_q;
   end

   // A misaligned word request never reaches memory (R2)
   p_word_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd2 && req_addr[1:0] != 2'd0) |-> !mem_req);

   // A rejected valid request is answered by a trap next cycle (R4)
   p_trap_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mem_req) |=> (trap && !wb_valid));

   // Trap address captures the faulting request address (R4)
   p_trap_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mem_req) |=> (trap_addr == $past(req_addr)));

   // Issued load is answered by write-back next cycle (R5)
   p_load_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> (wb_valid && !trap));

   // Store or idle cycle yields no write-back (R11)
   p_store_no_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || req_is_store) |=> !wb_valid);

   // Idle cycle issues nothing (R11)
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !mem_req);

   // Write-back and trap never coincide (R4)
   p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wb_valid && trap));

endmodule

// File: tb/sim_mem_lane_align.sv
`timescale 1ns/1ps
module sim_mem_lane_align;

   localparam int ADDR_W = 32;
   localparam int DATA_W = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_is_store = 1'b0;
   logic [1:0]        req_size = 2'd0;
   logic              req_signed = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              mem_req;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_be;
   logic [DATA_W-1:0] mem_wdata;
   logic [DATA_W-1:0] mem_rdata = '0;
   logic              wb_valid;
   logic [DATA_W-1:0] wb_data;
   logic              trap;
   logic              trap_is_store;
   logic [ADDR_W-1:0] trap_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   mem_lane_align #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
      .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
      .req_wdata(req_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .wb_valid(wb_valid), .wb_data(wb_data), .trap(trap),
      .trap_is_store(trap_is_store), .trap_addr(trap_addr)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_one(input int sz, input int off, input bit sg, input bit st,
                          input logic [63:0] pat);
      logic [ADDR_W-1:0] a;
      bit                mis;
      int                nb;
      logic [63:0]       raw;
      logic [63:0]       lowmask;
      logic [7:0]        be_exp;
      a   = 32'h1234_5670 | 32'(off);
      mis = ((off & ((1 << sz) - 1)) != 0);
      nb  = 1 << sz;
      @(negedge clk);
      req_valid    = 1'b1;
      req_is_store = st;
      req_size     = 2'(sz);
      req_signed   = sg;
      req_addr     = a;
      req_wdata    = pat;
      #1;
      if (mis) begin
         chk("R2 mem_req on misaligned", 64'(mem_req), 64'd0);
      end else begin
         chk("R3 mem_req", 64'(mem_req), 64'd1);
         chk("R3 mem_we", 64'(mem_we), 64'(st));
         chk("R3 mem_addr", 64'(mem_addr), 64'(a & ~32'h7));
         if (st) begin
            be_exp = 8'(((16'h1 << nb) - 16'h1) << off);
            chk("R9 mem_be", 64'(mem_be), 64'(be_exp));
            chk("R10 mem_wdata", mem_wdata, pat << (8 * off));
         end
      end
      @(negedge clk);
      req_valid = 1'b0;
      mem_rdata = pat;
      #1;
      if (mis) begin
         chk("R4 trap", 64'(trap), 64'd1);
         chk("R4 no wb", 64'(wb_valid), 64'd0);
         chk("R4 trap_addr", 64'(trap_addr), 64'(a));
         chk("R4 trap_is_store", 64'(trap_is_store), 64'(st));
      end else if (st) begin
         chk("R11 store no wb", 64'(wb_valid), 64'd0);
         chk("R11 store no trap", 64'(trap), 64'd0);
      end else begin
         chk("R5 wb_valid", 64'(wb_valid), 64'd1);
         chk("R5 no trap", 64'(trap), 64'd0);
         raw = pat >> (8 * off);
         if (sz < 3) begin
            lowmask = (64'h1 << (8 * nb)) - 64'h1;
            raw = raw & lowmask;
            if (sg && raw[8*nb-1]) raw = raw | ~lowmask;
            if (sg) chk("R8 R6 signed load", wb_data, raw);
            else    chk("R7 R6 unsigned load", wb_data, raw);
         end else begin
            chk("R8 dword load", wb_data, raw);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 wb_valid in reset", 64'(wb_valid), 64'd0);
      chk("R1 trap in reset", 64'(trap), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 wb_valid after reset", 64'(wb_valid), 64'd0);
      chk("R1 trap after reset", 64'(trap), 64'd0);
      chk("R11 idle mem_req", 64'(mem_req), 64'd0);
      @(negedge clk);
      chk("R11 idle no trap", 64'(trap), 64'd0);
      chk("R11 idle no wb", 64'(wb_valid), 64'd0);
      for (int p = 0; p < 2; p++) begin
         for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 8; off++) begin
               for (int sg = 0; sg < 2; sg++) begin
                  for (int st = 0; st < 2; st++) begin
                     run_one(sz, off, sg[0], st[0],
                             (p == 0) ? 64'hF1E2_D3C4_B5A6_9788 : 64'h0172_6354_4536_2718);
                  end
               end
            end
         end
      end
      @(negedge clk);
      chk("R11 idle after sweep", 64'(wb_valid | trap), 64'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule